// File: doc/BRIEF.md
# Flash Toggle Status Bit Generator

This block produces the two toggle-style status bits that a parallel NOR flash puts on its data bus while an embedded program or erase is running. A global busy toggle (`tgl_busy`) inverts on every status read while an operation is active. A per-sector toggle (`tgl_sect`) inverts only on reads that land in a sector chosen for erase. A third output, `show_status`, tells the data-path multiplexer whether the bus should carry status or array data.

The block watches the two read strobes, output-enable and chip-enable. It counts a read when both strobes are low and one of them has just gone low. Its other inputs come from the internal operation sequencer: a busy level, the operation kind, an erase-suspend level, a per-sector erase-selection mask and a per-sector protection mask. A single-cycle command pulse marks the rising edge of the final write pulse of a command sequence. If that command targets only protected storage, the block runs a timed toggle window on its own and then falls back to array reads.

Top module: `flash_toggle_status`

## Requirements
- R1: After reset `tgl_busy` and `tgl_sect` are 0. With all sequencer inputs idle, `show_status` is 0.
- R2: A read event occurs in the first clock cycle in which `oe_n` and `ce_n` are both sampled low. Either strobe may be the one that falls last. One low strobe alone is not a read.
- R3: While `op_busy` is 1, every read event inverts `tgl_busy`, whatever the read address, and `show_status` is 1.
- R4: While `op_busy`, `erase_susp` and the protect timer are all inactive, `tgl_busy` and `tgl_sect` hold on reads and `show_status` is 0.
- R5: A `cmd_go` pulse with `cmd_erase`=1, a non-zero `sel_mask` and every selected sector protected starts a timer. The timer keeps `show_status` at 1 for exactly `ERASE_PROT_CYC` cycles after the pulse edge, and `tgl_busy` inverts on reads during that window.
- R6: A `cmd_go` pulse with `cmd_erase`=0 whose `cmd_addr` falls in a protected sector keeps `show_status` at 1 for exactly `PROG_PROT_CYC` cycles.
- R7: An erase command with at least one unprotected selected sector does not start the timer. The same holds for a program command to an unprotected sector.
- R8: While `erase_susp` is 1 and `op_busy` is 0, `tgl_busy` holds on reads. On reads to a selected sector `tgl_sect` inverts and `show_status` is 1.
- R9: While `erase_susp` is 1 and `op_busy` is 0, reads to an unselected sector give `show_status`=0 and leave `tgl_sect` unchanged.
- R10: During a program inside erase-suspend (`erase_susp`=1, `op_busy`=1, `op_erase`=0), `tgl_busy` inverts on every read. `tgl_sect` still inverts only on reads to selected sectors.
- R11: `tgl_sect` inverts only on reads to selected sectors while an erase runs (`op_busy`=1 with `op_erase`=1) or is suspended. During a plain program it holds.
- R12: The sector index is the top `SECT_W` bits of the address. Bit i of `sel_mask` and of `prot_mask` belongs to sector i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| oe_n | input | 1 | Output-enable strobe, active low |
| ce_n | input | 1 | Chip-enable strobe, active low |
| rd_addr | input | ADDR_W | Address of the current read |
| op_busy | input | 1 | Sequencer is running an embedded program or erase |
| op_erase | input | 1 | 1 = the running operation is an erase, 0 = a program |
| erase_susp | input | 1 | An erase is suspended |
| sel_mask | input | NSECT | Sectors selected for erase |
| prot_mask | input | NSECT | Protected sectors |
| cmd_go | input | 1 | One-cycle pulse at the end of a command sequence |
| cmd_erase | input | 1 | 1 = the command is an erase, 0 = a program |
| cmd_addr | input | ADDR_W | Target address of a program command |
| tgl_busy | output | 1 | Global busy toggle bit |
| tgl_sect | output | 1 | Per-sector erase toggle bit |
| show_status | output | 1 | 1 = the data bus carries status, 0 = array data |

## Verification
The checks assume the strobes and sequencer inputs are synchronous to `clk`. They also assume `cmd_go` lasts one cycle, and that the sequencer drops `op_busy` while an erase is suspended unless a suspend-program is running, with `op_erase`=0 during that program. The stimulus changes every input on the falling clock edge and moves each mode only through those legal combinations. It sweeps all selection masks against every sector in the suspend sweep, which exercises the sector map and the selected/unselected split in both directions.

// File: rtl/ftsg_pkg.sv
// Package: shared types for the flash toggle status generator.
// Assumes nothing beyond being compiled before the modules that import it.
package ftsg_pkg;
    // Operation kind as signalled by the sequencer and the command pulse.
    typedef enum logic {
        OPK_PROG  = 1'b0,
        OPK_ERASE = 1'b1
    } op_kind_e;
endpackage

// File: rtl/ftsg_rd_strobe.sv
// Module: read event detector.
// Gives a one-cycle pulse in the first cycle where both active-low strobes
// are low. Assumes the strobes are synchronous to clk.
module ftsg_rd_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n,
    input  logic ce_n,
    output logic rd_evt
);
    logic rd_act;
    logic rd_q;

    assign rd_act = ~oe_n & ~ce_n;

    // Remember whether a read was already active last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= rd_act;
    end

    assign rd_evt = rd_act & ~rd_q;
endmodule

// File: rtl/ftsg_sect_hit.sv
// Module: sector membership test.
// Maps the top SECT_W address bits to a sector index and reports whether
// that sector's bit is set in the mask. Assumes a uniform sector map.
module ftsg_sect_hit #(
    parameter int ADDR_W = 8,
    parameter int SECT_W = 2,
    localparam int NSECT = 1 << SECT_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [NSECT-1:0]  mask,
    output logic              hit
);
    logic [SECT_W-1:0] idx;
    logic [NSECT-1:0]  match;

    assign idx = addr[ADDR_W-1 -: SECT_W];

    // One comparator per sector, gated by that sector's mask bit.
    for (genvar i = 0; i < NSECT; i++) begin : g_sect
        assign match[i] = mask[i] & (idx == SECT_W'(i));
    end

    assign hit = |match;
endmodule

// File: rtl/ftsg_prot_timer.sv
// Module: protected-target toggle window timer.
// Loads one of two cycle counts and counts down to zero; busy while non-zero.
// Assumes at most one load request per cycle (erase has priority).
module ftsg_prot_timer #(
    parameter int ERASE_CYC = 40,
    parameter int PROG_CYC  = 8,
    localparam int MAXC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC,
    localparam int CNT_W = $clog2(MAXC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_erase,
    input  logic             load_prog,
    output logic             busy,
    output logic [CNT_W-1:0] cnt
);
    // Load on request, otherwise count down while non-zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load_erase)   cnt <= CNT_W'(ERASE_CYC);
        else if (load_prog)    cnt <= CNT_W'(PROG_CYC);
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/flash_toggle_status.sv
// Module: top of the flash toggle status generator.
// Drives the global busy toggle, the per-sector erase toggle and the
// status/array select. Assumes the sequencer holds op_busy low during a
// suspended erase except while a suspend-program runs (with op_erase low),
// and that cmd_go is a single-cycle pulse.
module flash_toggle_status
    import ftsg_pkg::*;
#(
    parameter int ADDR_W         = 8,
    parameter int SECT_W         = 2,
    parameter int ERASE_PROT_CYC = 40,
    parameter int PROG_PROT_CYC  = 8,
    localparam int NSECT = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oe_n,
    input  logic              ce_n,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              op_busy,
    input  logic              op_erase,
    input  logic              erase_susp,
    input  logic [NSECT-1:0]  sel_mask,
    input  logic [NSECT-1:0]  prot_mask,
    input  logic              cmd_go,
    input  logic              cmd_erase,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              tgl_busy,
    output logic              tgl_sect,
    output logic              show_status
);
    localparam int MAXC  = (ERASE_PROT_CYC > PROG_PROT_CYC) ? ERASE_PROT_CYC : PROG_PROT_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    logic             rd_evt;
    logic             rd_hit;
    logic             cmd_prot_hit;
    logic             tmr_busy;
    logic [CNT_W-1:0] tmr_cnt;
    logic             ld_erase;
    logic             ld_prog;
    logic             toggle_on;
    logic             erase_live;
    op_kind_e         cmd_kind;
    op_kind_e         run_kind;

    ftsg_rd_strobe u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .oe_n   (oe_n),
        .ce_n   (ce_n),
        .rd_evt (rd_evt)
    );

    ftsg_sect_hit #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_rd_sect (
        .addr (rd_addr),
        .mask (sel_mask),
        .hit  (rd_hit)
    );

    ftsg_sect_hit #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_cmd_sect (
        .addr (cmd_addr),
        .mask (prot_mask),
        .hit  (cmd_prot_hit)
    );

    ftsg_prot_timer #(.ERASE_CYC(ERASE_PROT_CYC), .PROG_CYC(PROG_PROT_CYC)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_erase (ld_erase),
        .load_prog  (ld_prog),
        .busy       (tmr_busy),
        .cnt        (tmr_cnt)
    );

    assign cmd_kind = op_kind_e'(cmd_erase);
    assign run_kind = op_kind_e'(op_erase);

    // Decide whether a command hits only protected storage.
    always_comb begin
        ld_erase = 1'b0;
        ld_prog  = 1'b0;
        if (cmd_go) begin
            if (cmd_kind == OPK_ERASE)
                ld_erase = (sel_mask != '0) && ((sel_mask & ~prot_mask) == '0);
            else
                ld_prog  = cmd_prot_hit;
        end
    end

    assign toggle_on   = op_busy | tmr_busy;
    assign erase_live  = (op_busy & (run_kind == OPK_ERASE)) | erase_susp;
    assign show_status = toggle_on | (erase_susp & rd_hit);

    // Global toggle: flips on every read while an operation is live.
    always_ff @(posedge clk) begin
        if (!rst_n)                     tgl_busy <= 1'b0;
        else if (rd_evt && toggle_on)   tgl_busy <= ~tgl_busy;
    end

    // Sector toggle: flips on reads to selected sectors of a live erase.
    always_ff @(posedge clk) begin
        if (!rst_n)                               tgl_sect <= 1'b0;
        else if (rd_evt && rd_hit && erase_live)  tgl_sect <= ~tgl_sect;
    end
endmodule

// File: rtl/ftsg_checker.sv
// Module: property checker for flash_toggle_status, attached by bind.
// Assumes the same input discipline as the top module.
module ftsg_checker #(
    parameter int MAXC  = 40,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_evt,
    input logic             rd_hit,
    input logic             op_busy,
    input logic             erase_susp,
    input logic             tmr_busy,
    input logic [CNT_W-1:0] tmr_cnt,
    input logic             tgl_busy,
    input logic             tgl_sect,
    input logic             show_status
);
    // R3
    busy_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && (op_busy || tmr_busy)) |=> (tgl_busy != $past(tgl_busy)));

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_busy || tmr_busy) |=> $stable(tgl_busy));

    // R9
    sect_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && !rd_hit) |=> $stable(tgl_sect));

    // R2
    no_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_evt |=> ($stable(tgl_busy) && $stable(tgl_sect)));

    // R4
    array_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_busy || tmr_busy || erase_susp) |-> !show_status);

    // R5
    tmr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tmr_cnt) <= MAXC);
endmodule

bind flash_toggle_status ftsg_checker #(.MAXC(MAXC), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_evt      (rd_evt),
    .rd_hit      (rd_hit),
    .op_busy     (op_busy),
    .erase_susp  (erase_susp),
    .tmr_busy    (tmr_busy),
    .tmr_cnt     (tmr_cnt),
    .tgl_busy    (tgl_busy),
    .tgl_sect    (tgl_sect),
    .show_status (show_status)
);

// File: tb/flash_toggle_status_tb.sv
// Bench: directed sweeps over a 4-sector, 8-bit-address configuration.
module flash_toggle_status_tb;
    localparam int ADDR_W = 8;
    localparam int SECT_W = 2;
    localparam int NSECT  = 4;
    localparam int ECYC   = 40;
    localparam int PCYC   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              oe_n = 1'b1, ce_n = 1'b1;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              op_busy = 1'b0, op_erase = 1'b0, erase_susp = 1'b0;
    logic [NSECT-1:0]  sel_mask = '0, prot_mask = '0;
    logic              cmd_go = 1'b0, cmd_erase = 1'b0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic              tgl_busy, tgl_sect, show_status;

    int checks = 0;
    int errors = 0;
    logic e6, e2;
    logic s6, s2, sst;
    bit via_ce = 1'b0;

    always #2.5 clk = ~clk;

    flash_toggle_status #(.ADDR_W(ADDR_W), .SECT_W(SECT_W),
                          .ERASE_PROT_CYC(ECYC), .PROG_PROT_CYC(PCYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .ce_n(ce_n), .rd_addr(rd_addr),
        .op_busy(op_busy), .op_erase(op_erase), .erase_susp(erase_susp),
        .sel_mask(sel_mask), .prot_mask(prot_mask), .cmd_go(cmd_go),
        .cmd_erase(cmd_erase), .cmd_addr(cmd_addr), .tgl_busy(tgl_busy),
        .tgl_sect(tgl_sect), .show_status(show_status));

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // One read to sector sec; strobes alternate which one falls last (R2).
    task automatic rd(input int sec);
        @(negedge clk);
        rd_addr = ADDR_W'((sec << (ADDR_W - SECT_W)) | 5);
        if (via_ce) oe_n = 1'b0; else ce_n = 1'b0;
        @(negedge clk);
        if (via_ce) ce_n = 1'b0; else oe_n = 1'b0;
        @(negedge clk);
        s6 = tgl_busy; s2 = tgl_sect; sst = show_status;
        oe_n = 1'b1; ce_n = 1'b1;
        via_ce = ~via_ce;
    endtask

    // Pulse a command and check the status window length (R5/R6/R7).
    task automatic cmd(input logic er, input int sec, input int n, input string tag);
        @(negedge clk);
        cmd_go = 1'b1; cmd_erase = er;
        cmd_addr = ADDR_W'(sec << (ADDR_W - SECT_W));
        @(negedge clk);
        cmd_go = 1'b0;
        for (int k = 0; k <= n; k++) begin
            if (k == 0 || k == n - 1 || k == n) chk(show_status, (k < n), tag);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(tgl_busy, 1'b0, "R1 busy toggle reset");
        chk(tgl_sect, 1'b0, "R1 sector toggle reset");
        chk(show_status, 1'b0, "R1 status reset");
        rst_n = 1'b1;
        e6 = 1'b0; e2 = 1'b0;

        // R4: idle reads leave both toggles alone.
        for (int s = 0; s < NSECT; s++) begin
            rd(s);
            chk(s6, e6, "R4 idle busy toggle");
            chk(sst, 1'b0, "R4 idle status");
        end

        // R3/R11: program busy, all sectors, dq2 holds.
        sel_mask = 4'b0101; op_busy = 1'b1; op_erase = 1'b0;
        for (int s = 0; s < NSECT; s++) begin
            rd(s); e6 = ~e6;
            chk(s6, e6, "R3 program busy toggle");
            chk(s2, e2, "R11 program sector toggle hold");
            chk(sst, 1'b1, "R3 status while busy");
        end

        // R2: a single low strobe is not a read.
        @(negedge clk); oe_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(tgl_busy, e6, "R2 single strobe no read");
        oe_n = 1'b1;

        // R11/R12: active erase, selected sectors 0 and 2.
        op_erase = 1'b1;
        for (int s = 0; s < NSECT; s++) begin
            rd(s); e6 = ~e6;
            if (sel_mask[s]) e2 = ~e2;
            chk(s6, e6, "R3 erase busy toggle");
            chk(s2, e2, "R12 erase sector toggle by map");
        end

        // R8/R9/R12: suspend sweep over all masks and sectors.
        op_busy = 1'b0; erase_susp = 1'b1;
        for (int m = 0; m < 16; m++) begin
            sel_mask = 4'(m);
            for (int s = 0; s < NSECT; s++) begin
                rd(s);
                if (sel_mask[s]) e2 = ~e2;
                chk(s6, e6, "R8 suspend busy toggle frozen");
                chk(s2, e2, sel_mask[s] ? "R8 suspend sector toggle" : "R9 unselected hold");
                chk(sst, sel_mask[s], sel_mask[s] ? "R8 suspend status" : "R9 suspend array read");
            end
        end

        // R10: program inside erase-suspend.
        sel_mask = 4'b0001; op_busy = 1'b1; op_erase = 1'b0;
        for (int s = 0; s < NSECT; s++) begin
            rd(s); e6 = ~e6;
            if (s == 0) e2 = ~e2;
            chk(s6, e6, "R10 suspend-program busy toggle");
            chk(s2, e2, "R10 suspend-program sector toggle");
            chk(sst, 1'b1, "R10 suspend-program status");
        end
        op_busy = 1'b0; erase_susp = 1'b0;

        // R4: after completion, array mode.
        rd(1);
        chk(s6, e6, "R4 done busy toggle hold");
        chk(sst, 1'b0, "R4 done array read");

        // R5: erase of only protected sectors.
        sel_mask = 4'b0011; prot_mask = 4'b0111;
        cmd(1'b1, 0, ECYC, "R5 protected erase window");
        @(negedge clk); cmd_go = 1'b1; cmd_erase = 1'b1;
        @(negedge clk); cmd_go = 1'b0;
        for (int r = 0; r < 3; r++) begin
            rd(3); e6 = ~e6;
            chk(s6, e6, "R5 toggle during protected window");
        end
        repeat (ECYC) @(negedge clk);
        chk(show_status, 1'b0, "R5 window over");

        // R7: partially protected erase, unprotected program.
        prot_mask = 4'b0001;
        cmd(1'b1, 0, 0, "R7 partial protect erase no window");
        prot_mask = 4'b1000;
        cmd(1'b0, 1, 0, "R7 unprotected program no window");

        // R6: program to a protected sector.
        cmd(1'b0, 3, PCYC, "R6 protected program window");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule